// File: doc/BRIEF.md
# Saturating Wide-Dividend Integer Divider

This block divides a 64-bit dividend by a 32-bit divisor and returns a 32-bit quotient that is clamped rather than wrapped when the true result is too wide. The dividend is built by placing a 32-bit upper-half value above the low 32 bits of operand A. The divisor is the low 32 bits of operand B. Upper operand bits are ignored. A mode input selects signed or unsigned arithmetic. A second mode input selects whether the pair of condition-code outputs is loaded with the result.

A request is made by pulsing `start_i` while the block is idle. The block runs a restoring shift-subtract loop on operand magnitudes, one quotient bit per clock. It then corrects the sign and applies the saturation rules. Finally it pulses `done_o` with the quotient, an overflow flag and a divide-by-zero flag. A zero divisor is detected at acceptance and reported on the next cycle, without iterating. The trap is only a flag; handling it is left to the surrounding pipeline.

Top module: `sat_wide_divider`

## Requirements
- R1: The dividend is {hi_i[31:0], a_i[31:0]} and the divisor is b_i[31:0]. Bits a_i[63:32] and b_i[63:32] have no effect on any output, including the zero-divisor decision.
- R2: In unsigned mode (signed_i=0), a quotient below 2^32 is returned exactly, truncated, with ovf_o=0.
- R3: In unsigned mode, a true quotient of 2^32 or more returns 0xFFFFFFFF with ovf_o=1.
- R4: In signed mode (signed_i=1), both operands are two's complement. A quotient in [-2^31, 2^31-1] is returned exactly, rounded toward zero, with ovf_o=0.
- R5: In signed mode, a quotient above 2^31-1 returns 0x7FFFFFFF and one below -2^31 returns 0x80000000, each with ovf_o=1. The most negative 64-bit dividend divided by -1 gives 0x7FFFFFFF with ovf_o=1.
- R6: A zero divisor produces done_o with dz_trap_o=1, quot_o=0 and ovf_o=0, one cycle after the accepting edge. dz_trap_o is 0 on every other completion.
- R7: When setcc_i was 1 at acceptance and the divisor is non-zero, cc_val_o and cc_ovf_o take quot_o and ovf_o in the done cycle. Otherwise, including on a zero-divisor trap, they hold their value.
- R8: A non-zero division raises done_o for one cycle, starting 65 rising edges after the accepting edge. busy_o is high from acceptance until done_o. After reset, done_o, busy_o, quot_o, ovf_o, dz_trap_o, cc_val_o and cc_ovf_o are 0.
- R9: start_i is accepted only when busy_o is 0. A start_i pulse while busy changes neither the running operation nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a division (taken when idle) |
| signed_i | input | 1 | 1 = signed operation, 0 = unsigned |
| setcc_i | input | 1 | 1 = load condition-code outputs on completion |
| hi_i | input | 32 | Upper half of the dividend |
| a_i | input | 64 | Operand A; low 32 bits are the dividend's lower half |
| b_i | input | 64 | Operand B; low 32 bits are the divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Saturated quotient |
| ovf_o | output | 1 | Quotient was clamped |
| dz_trap_o | output | 1 | Divisor was zero |
| cc_val_o | output | 32 | Condition-code source: quotient |
| cc_ovf_o | output | 1 | Condition-code source: overflow flag |

## Verification
The assertions assume that start_i, signed_i, setcc_i and the operands are known values at every sampled edge after reset. They also assume that the mode inputs and operands are valid in the accepting cycle, since they are captured only then. The bench drives every input from time zero and changes inputs only half a cycle away from the rising edge. It draws operands from a fixed-seed generator, biased so that upper halves are often zero, sign extensions or small. This makes exact, clamped and trapping results all appear. Directed cases add the boundary quotients, a start pulse while busy, and divisors whose only non-zero bits are in the ignored upper half.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
  localparam int QW = 32;
  localparam int DW = 2 * QW;
  localparam int ITER = DW;

  localparam logic [DW-1:0] NEG_LIM = {{(DW-QW){1'b0}}, 1'b1, {(QW-1){1'b0}}};
  localparam logic [DW-1:0] POS_LIM = {{(DW-QW){1'b0}}, 1'b0, {(QW-1){1'b1}}};

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} div_state_e;

  typedef struct packed {
    logic [QW:0]   rem;
    logic [DW-1:0] acc;
  } step_t;

  typedef struct packed {
    logic [QW-1:0] q;
    logic          ovf;
  } sat_res_t;

  // Absolute value of a wide two's complement number (unsigned if sgn=0).
  function automatic logic [DW-1:0] mag_wide(input logic [DW-1:0] v, input logic sgn);
    return (sgn && v[DW-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [QW-1:0] mag_narrow(input logic [QW-1:0] v, input logic sgn);
    return (sgn && v[QW-1]) ? (~v + 1'b1) : v;
  endfunction

  // One restoring step: shift the next dividend bit into the partial
  // remainder, subtract the divisor when it fits, record the quotient bit.
  function automatic step_t div_step(input step_t cur, input logic [QW-1:0] dvs);
    step_t         nxt;
    logic [QW:0]   trial;
    logic          qbit;
    trial = {cur.rem[QW-1:0], cur.acc[DW-1]};
    qbit  = (trial >= {1'b0, dvs});
    nxt.rem = qbit ? (trial - {1'b0, dvs}) : trial;
    nxt.acc = {cur.acc[DW-2:0], qbit};
    return nxt;
  endfunction

  // Clamp the full-width magnitude quotient into QW bits and apply the sign.
  function automatic sat_res_t saturate(input logic [DW-1:0] mag, input logic neg,
                                        input logic sgn);
    sat_res_t r;
    r.q   = mag[QW-1:0];
    r.ovf = 1'b0;
    if (!sgn) begin
      if (|mag[DW-1:QW]) begin
        r.q   = '1;
        r.ovf = 1'b1;
      end
    end else if (neg) begin
      if (mag > NEG_LIM) begin
        r.q   = NEG_LIM[QW-1:0];
        r.ovf = 1'b1;
      end else begin
        r.q = ~mag[QW-1:0] + 1'b1;
      end
    end else begin
      if (mag > POS_LIM) begin
        r.q   = POS_LIM[QW-1:0];
        r.ovf = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/div_prep.sv
`timescale 1ns/1ps
module div_prep
  import div_pkg::*;
(
  input  logic          sgn_i,
  input  logic [QW-1:0] hi_i,
  input  logic [QW-1:0] lo_i,
  input  logic [QW-1:0] dvs_i,
  output logic [DW-1:0] dvd_mag_o,
  output logic [QW-1:0] dvs_mag_o,
  output logic          q_neg_o,
  output logic          dvs_zero_o
);
  logic [DW-1:0] dvd_full;

  assign dvd_full   = {hi_i, lo_i};
  assign dvd_mag_o  = mag_wide(dvd_full, sgn_i);
  assign dvs_mag_o  = mag_narrow(dvs_i, sgn_i);
  assign q_neg_o    = sgn_i & (hi_i[QW-1] ^ dvs_i[QW-1]);
  assign dvs_zero_o = (dvs_i == '0);
endmodule

// File: rtl/div_iter.sv
`timescale 1ns/1ps
module div_iter
  import div_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [QW-1:0] dvs_i,
  output logic          run_o,
  output logic          last_o,
  output logic [DW-1:0] quo_o
);
  localparam int CW = $clog2(ITER);

  step_t         st_q;
  logic [QW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  step_t         st_nxt;

  assign st_nxt = div_step(st_q, dvs_q);
  assign last_o = run_q && (cnt_q == CW'(ITER - 1));
  assign run_o  = run_q;
  assign quo_o  = st_q.acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      st_q.rem <= '0;
      st_q.acc <= dvd_i;
      dvs_q    <= dvs_i;
      cnt_q    <= '0;
      run_q    <= 1'b1;
    end else if (run_q) begin
      st_q  <= st_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (last_o) run_q <= 1'b0;
    end
  end

  // R8: the loop stops right after its final step.
  a_r8_last_stops: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !run_q);
  // R9: the controller never reloads the loop while it is iterating.
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !run_q);
endmodule

// File: rtl/div_sat.sv
`timescale 1ns/1ps
module div_sat
  import div_pkg::*;
(
  input  logic          sgn_i,
  input  logic          neg_i,
  input  logic [DW-1:0] mag_i,
  output logic [QW-1:0] q_o,
  output logic          ovf_o
);
  sat_res_t res;

  assign res   = saturate(mag_i, neg_i, sgn_i);
  assign q_o   = res.q;
  assign ovf_o = res.ovf;

  // R3/R5: a clamped result is always one of the three limit codes.
  always_comb begin
    a_r5_limit_code: assert (!ovf_o || q_o == '1 || q_o == NEG_LIM[QW-1:0]
                             || q_o == POS_LIM[QW-1:0]);
  end
endmodule

// File: rtl/sat_wide_divider.sv
`timescale 1ns/1ps
module sat_wide_divider
  import div_pkg::*;
#(
  parameter int OPW = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic           setcc_i,
  input  logic [QW-1:0]  hi_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [QW-1:0]  quot_o,
  output logic           ovf_o,
  output logic           dz_trap_o,
  output logic [QW-1:0]  cc_val_o,
  output logic           cc_ovf_o
);
  div_state_e    state_q;
  logic          sgn_q, cc_q, neg_q;
  logic [DW-1:0] dvd_mag;
  logic [QW-1:0] dvs_mag;
  logic          q_neg, dvs_zero;
  logic          accept, go_iter;
  logic          iter_run, iter_last;
  logic [DW-1:0] iter_quo;
  logic [QW-1:0] sat_q;
  logic          sat_ovf;
  logic          unused_hi;

  assign unused_hi = ^{a_i[OPW-1:QW], b_i[OPW-1:QW]};
  assign busy_o    = (state_q != ST_IDLE);
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign go_iter   = accept && !dvs_zero;

  div_prep u_prep (
    .sgn_i      (signed_i),
    .hi_i       (hi_i),
    .lo_i       (a_i[QW-1:0]),
    .dvs_i      (b_i[QW-1:0]),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .q_neg_o    (q_neg),
    .dvs_zero_o (dvs_zero)
  );

  div_iter u_iter (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (go_iter),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .run_o  (iter_run),
    .last_o (iter_last),
    .quo_o  (iter_quo)
  );

  div_sat u_sat (
    .sgn_i (sgn_q),
    .neg_i (neg_q),
    .mag_i (iter_quo),
    .q_o   (sat_q),
    .ovf_o (sat_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sgn_q     <= 1'b0;
      cc_q      <= 1'b0;
      neg_q     <= 1'b0;
      done_o    <= 1'b0;
      quot_o    <= '0;
      ovf_o     <= 1'b0;
      dz_trap_o <= 1'b0;
      cc_val_o  <= '0;
      cc_ovf_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sgn_q <= signed_i;
          cc_q  <= setcc_i;
          neg_q <= q_neg;
          if (dvs_zero) begin
            quot_o    <= '0;
            ovf_o     <= 1'b0;
            dz_trap_o <= 1'b1;
            done_o    <= 1'b1;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (iter_last) state_q <= ST_FIN;
        ST_FIN: begin
          quot_o    <= sat_q;
          ovf_o     <= sat_ovf;
          dz_trap_o <= 1'b0;
          done_o    <= 1'b1;
          if (cc_q) begin
            cc_val_o <= sat_q;
            cc_ovf_o <= sat_ovf;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: an unsigned clamp always yields the all-ones code.
  a_r3_unsigned_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !sgn_q && ovf_o) |-> (quot_o == '1));
  // R6: a trap carries a zero quotient and no overflow.
  a_r6_trap_clean: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap_o |-> (quot_o == '0 && !ovf_o));
  // R7: a trap leaves the condition-code outputs untouched.
  a_r7_cc_hold_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dz_trap_o) |-> ($stable(cc_val_o) && $stable(cc_ovf_o)));
  // R8: completion is reported only once the block is idle again.
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R8: the iteration loop only runs while the controller reports busy.
  a_r8_run_busy: assert property (@(posedge clk) disable iff (!rst_n)
    iter_run |-> busy_o);
  // R9: a start while busy does not recapture the modes.
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(sgn_q) && $stable(cc_q) && $stable(neg_q)));
endmodule

// File: tb/sat_wide_divider_bench.sv
`timescale 1ns/1ps
module sat_wide_divider_bench;
  localparam int ITER = 64;
  localparam logic signed [65:0] SMAX = 66'sd2147483647;
  localparam logic signed [65:0] SMIN = -66'sd2147483648;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic        setcc_i = 1'b0;
  logic [31:0] hi_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        busy_o, done_o, ovf_o, dz_trap_o, cc_ovf_o;
  logic [31:0] quot_o, cc_val_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] exp_cc = '0;
  logic        exp_cco = 1'b0;

  always #4 clk = ~clk;

  sat_wide_divider u_sat_wide_divider (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .setcc_i(setcc_i), .hi_i(hi_i), .a_i(a_i), .b_i(b_i), .busy_o(busy_o),
    .done_o(done_o), .quot_o(quot_o), .ovf_o(ovf_o), .dz_trap_o(dz_trap_o),
    .cc_val_o(cc_val_o), .cc_ovf_o(cc_ovf_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference computed with wide signed arithmetic, not magnitudes.
  task automatic ref_div(input bit sgn, input logic [31:0] y, input logic [31:0] a,
                         input logic [31:0] b, output logic [31:0] q,
                         output bit ovf, output bit dz);
    logic [63:0] u;
    logic signed [65:0] n, d, r;
    q = '0; ovf = 0; dz = 0;
    if (b == 32'h0) begin
      dz = 1;
    end else if (!sgn) begin
      u = {y, a} / {32'h0, b};
      if (u > 64'h0000_0000_FFFF_FFFF) begin q = '1; ovf = 1; end
      else q = u[31:0];
    end else begin
      n = {{2{y[31]}}, y, a};
      d = {{34{b[31]}}, b};
      if (b == 32'hFFFF_FFFF) r = -n;
      else r = n / d;
      if (r > SMAX) begin q = 32'h7FFF_FFFF; ovf = 1; end
      else if (r < SMIN) begin q = 32'h8000_0000; ovf = 1; end
      else q = r[31:0];
    end
  endtask

  task automatic run_op(input bit sgn, input bit cc, input logic [31:0] y,
                        input logic [63:0] a, input logic [63:0] b, input string rq);
    logic [31:0] eq;
    bit eo, ez;
    int n;
    string tag;
    ref_div(sgn, y, a[31:0], b[31:0], eq, eo, ez);
    if (rq != "") tag = rq;
    else if (ez) tag = "R6";
    else if (sgn) tag = eo ? "R5" : "R4";
    else tag = eo ? "R3" : "R2";
    @(negedge clk);
    start_i = 1; signed_i = sgn; setcc_i = cc; hi_i = y; a_i = a; b_i = b;
    n = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      if (n == 1) start_i = 0;
      if (done_o || n > ITER + 10) break;
    end
    check(n == (ez ? 1 : ITER + 2), "R8", "latency", 64'(n), 64'(ez ? 1 : ITER + 2));
    check(quot_o == eq, tag, "quotient", 64'(quot_o), 64'(eq));
    check(ovf_o == eo, tag, "overflow", 64'(ovf_o), 64'(eo));
    check(dz_trap_o == ez, "R6", "trap flag", 64'(dz_trap_o), 64'(ez));
    if (cc && !ez) begin exp_cc = eq; exp_cco = eo; end
    check(cc_val_o == exp_cc && cc_ovf_o == exp_cco, "R7", "cc outputs",
          {31'h0, cc_ovf_o, cc_val_o}, {31'h0, exp_cco, exp_cc});
    @(posedge clk); #1;
    check(!done_o && !busy_o, "R8", "single done pulse", {62'h0, done_o, busy_o}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] y, a32, b32;
    logic [31:0] eq;
    bit eo, ez;
    int mode;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(!done_o && !busy_o && quot_o == 0 && !ovf_o && !dz_trap_o, "R8", "reset state",
          {29'h0, done_o, busy_o, dz_trap_o, quot_o}, 64'h0);
    check(cc_val_o == 0 && !cc_ovf_o, "R7", "reset cc", {31'h0, cc_ovf_o, cc_val_o}, 64'h0);
    @(negedge clk); rst_n = 1;

    run_op(0, 1, 32'h0, 64'd100, 64'd7, "R2");
    run_op(0, 1, 32'h0, 64'hFFFF_FFFF, 64'd1, "R2");
    run_op(0, 1, 32'h1, 64'h0, 64'd1, "R3");
    run_op(1, 1, 32'h8000_0000, 64'h0, 64'hFFFF_FFFF, "R5");
    run_op(1, 1, 32'hFFFF_FFFF, 64'hFFFF_FFF9, 64'd2, "R4");
    run_op(1, 0, 32'hFFFF_FFFF, 64'h8000_0000, 64'd1, "R4");
    run_op(1, 0, 32'hFFFF_FFFF, 64'h7FFF_FFFF, 64'd1, "R5");
    run_op(1, 1, 32'h0, 64'h8000_0000, 64'd1, "R5");
    run_op(0, 1, 32'h0, 64'hDEAD_0000_0000_0040, 64'h1234_5678_0000_0000, "R1");
    run_op(0, 1, 32'h0, 64'hFFFF_FFFF_0000_0063, 64'hAAAA_0000_0000_0009, "R1");
    run_op(1, 0, 32'h0, 64'd5, 64'd3, "R7");

    // R9: a second start while busy must not disturb the first operation.
    ref_div(0, 32'h0, 32'd1000, 32'd10, eq, eo, ez);
    @(negedge clk);
    start_i = 1; signed_i = 0; setcc_i = 0; hi_i = 0; a_i = 64'd1000; b_i = 64'd10;
    @(negedge clk); start_i = 0;
    repeat (10) @(negedge clk);
    start_i = 1; signed_i = 1; hi_i = 32'hFFFF_FFFF; a_i = 64'd3; b_i = 64'h0;
    #1;
    check(busy_o, "R9", "busy while running", 64'(busy_o), 64'h1);
    @(negedge clk); start_i = 0;
    while (!done_o) @(negedge clk);
    check(quot_o == eq && !dz_trap_o, "R9", "result after ignored start",
          {31'h0, dz_trap_o, quot_o}, {32'h0, eq});

    for (int i = 0; i < 160; i++) begin
      mode = $urandom % 4;
      a32 = $urandom; b32 = $urandom;
      case (mode)
        0: y = 32'h0;
        1: y = a32[31] ? 32'hFFFF_FFFF : 32'h0;
        2: y = $urandom % 16;
        default: y = $urandom;
      endcase
      if ($urandom % 4 == 0) b32 = $urandom % 8;
      if ($urandom % 16 == 0) b32 = 32'h0;
      run_op(1'($urandom % 2), 1'($urandom % 2), y, {32'($urandom), a32},
             {32'($urandom), b32}, "");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule